// File: doc/BRIEF.md
# Power Status LED Blink Encoder

This block drives a single front-panel LED. A 2-bit mode field selects forced dark, forced lit, a copy of a user LED input, or a power-indicator mode. In the power-indicator mode the LED repeats a blink code built from a frame of eight equal time slots. The LED stays lit when every monitored rail reports good. When a rail has failed, the frame starts with a number of lit slots that names the rail, and the remaining slots are dark.

Slot timing comes from an internal prescaler. The prescaler counts pulses on a slot-tick enable input, and a parameter sets how many pulses make one slot. Each of the six power-good inputs passes through a two-flop synchronizer. The failure code is captured only when a frame begins, so every frame shows one complete code. When several rails fail together, the rail with the lowest code is shown.

Top module: `rail_blink_led`

## Requirements
- R1: While the synchronous reset `rst` is high, `ledOut` is 0 and the slot position and prescaler return to zero. The first frame after reset shows code 0, which means the LED is steady on in mode 01, even when a rail is already failing.
- R2: When `modeSel` is 2'b00, `ledOut` is 0 one clock edge later. When `modeSel` is 2'b11, `ledOut` is 1 one clock edge later.
- R3: When `modeSel` is 2'b10, `ledOut` equals the value `userLed` had at the previous clock edge.
- R4: When `modeSel` is 2'b01 and every `railGood` bit is 1, `ledOut` stays at 1 in every slot.
- R5: When `modeSel` is 2'b01, a frame has 8 slots. A failure code N lights slots 0 to N-1 and leaves slots N to 7 dark. The rail in `railGood` bit i has code i+1: bit0 = 1, bit1 = 2, bit2 = 3, bit3 = 4, bit4 = 5, bit5 = 6. A rail has failed when its bit is 0.
- R6: When several rails have failed, the code shown is that of the failed rail with the lowest bit index.
- R7: The code is captured at the start of each frame. A change in `railGood` during a frame does not alter that frame. The change appears in the first frame that starts at least 3 clock edges after it.
- R8: A slot lasts exactly `SLOT_TICKS` clock edges at which `tickEn` is 1. At an edge where `tickEn` is 0, the slot position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | LED mode: 00 dark, 01 power indicator, 10 user, 11 lit |
| userLed | input | 1 | LED value passed through in user mode |
| railGood | input | 6 | Power-good flags, one per rail, 1 = good; asynchronous |
| tickEn | input | 1 | Prescaler count enable, one pulse per base tick |
| ledOut | output | 1 | Registered LED drive |

## Verification
A wrong slot or prescaler count shows at the port within one frame. The lit run changes length, or the boundary between lit and dark slots moves off a multiple of `SLOT_TICKS` ticks. The checks compare whole 24-sample frames, so such an error is caught in the frame where it occurs. A code captured at the wrong time, or a wrong priority, shows a pulse count that differs from the expected one in the first full frame after the change. The mid-frame change test catches a capture that happens too early, because the corrupted frame is visible directly. A stuck or mis-selected mode path shows in the next clock cycle.

// File: rtl/rail_blink_pkg.sv
package rail_blink_pkg;
  localparam int RAIL_COUNT  = 6;
  localparam int FRAME_SLOTS = 8;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int CODE_W      = $clog2(RAIL_COUNT + 1);

  typedef enum logic [1:0] {
    LED_DARK  = 2'b00,
    LED_POWER = 2'b01,
    LED_USER  = 2'b10,
    LED_LIT   = 2'b11
  } led_mode_e;

  // Strobes from the slot sequencer to the LED datapath
  typedef struct packed {
    logic              frameWrap;  // last slot ends on this edge
    logic [SLOT_W-1:0] slotIdx;    // current slot within the frame
  } slot_strb_t;
endpackage

// File: rtl/rail_blink_ctrl.sv
module rail_blink_ctrl
  import rail_blink_pkg::*;
#(
  parameter int SLOT_TICKS = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  output slot_strb_t strb
);
  localparam int PRE_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(SLOT_TICKS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              slotAdv;

  assign slotAdv = tickEn && (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      slotCnt <= '0;
    end else if (tickEn) begin
      if (preCnt == PRE_LAST) begin
        preCnt  <= '0;
        slotCnt <= (slotCnt == SLOT_LAST) ? '0 : slotCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.slotIdx   = slotCnt;
    strb.frameWrap = slotAdv && (slotCnt == SLOT_LAST);
  end
endmodule

// File: rtl/rail_blink_dp.sv
module rail_blink_dp
  import rail_blink_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            modeSel,
  input  logic                  userLed,
  input  logic [RAIL_COUNT-1:0] railGood,
  input  slot_strb_t            strb,
  output logic                  ledOut
);
  logic [RAIL_COUNT-1:0] syncPipe [SYNC_STAGES];
  logic [CODE_W-1:0]     failCode;
  logic [CODE_W-1:0]     activeCode;
  logic                  powerLit;
  logic                  ledNext;

  // Synchronizer chain, reset to the all-good state
  always_ff @(posedge clk) begin
    if (rst) syncPipe[0] <= '1;
    else     syncPipe[0] <= railGood;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) syncPipe[s] <= '1;
      else     syncPipe[s] <= syncPipe[s-1];
    end
  end

  // Lowest failing index wins: scan from the top so it overwrites last
  always_comb begin
    failCode = '0;
    for (int i = RAIL_COUNT - 1; i >= 0; i--) begin
      if (!syncPipe[SYNC_STAGES-1][i]) failCode = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 activeCode <= '0;
    else if (strb.frameWrap) activeCode <= failCode;
  end

  assign powerLit = (activeCode == '0) || (int'(strb.slotIdx) < int'(activeCode));

  always_comb begin
    unique case (led_mode_e'(modeSel))
      LED_DARK:  ledNext = 1'b0;
      LED_POWER: ledNext = powerLit;
      LED_USER:  ledNext = userLed;
      LED_LIT:   ledNext = 1'b1;
      default:   ledNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ledOut <= 1'b0;
    else     ledOut <= ledNext;
  end
endmodule

// File: rtl/rail_blink_led.sv
module rail_blink_led
  import rail_blink_pkg::*;
#(
  parameter int SLOT_TICKS = 25
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            modeSel,
  input  logic                  userLed,
  input  logic [RAIL_COUNT-1:0] railGood,
  input  logic                  tickEn,
  output logic                  ledOut
);
  slot_strb_t slotStrb;

  rail_blink_ctrl #(.SLOT_TICKS(SLOT_TICKS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tickEn (tickEn),
    .strb   (slotStrb)
  );

  rail_blink_dp #(.SYNC_STAGES(2)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .modeSel  (modeSel),
    .userLed  (userLed),
    .railGood (railGood),
    .strb     (slotStrb),
    .ledOut   (ledOut)
  );
endmodule

// File: rtl/rail_blink_chk.sv
module rail_blink_chk
  import rail_blink_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] modeSel,
  input logic       userLed,
  input logic       tickEn,
  input logic       ledOut,
  input slot_strb_t strb
);
  a_r2_forced_off: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b00) |=> !ledOut);

  a_r2_forced_on: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b11) |=> ledOut);

  a_r3_user_copy: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b10) |=> (ledOut == $past(userLed)));

  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(strb.slotIdx));

  a_r8_slot_step: assert property (@(posedge clk) disable iff (rst)
    (strb.slotIdx != $past(strb.slotIdx)) |-> (strb.slotIdx == $past(strb.slotIdx) + 1'b1));

  a_r7_frame_restart: assert property (@(posedge clk) disable iff (rst)
    strb.frameWrap |=> (strb.slotIdx == '0));
endmodule

bind rail_blink_led rail_blink_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .modeSel (modeSel),
  .userLed (userLed),
  .tickEn  (tickEn),
  .ledOut  (ledOut),
  .strb    (slotStrb)
);

// File: tb/rail_blink_led_bench.sv
`timescale 1ns/1ps
module rail_blink_led_bench;
  localparam int TICKS = 3;
  localparam int FRAME = 8 * TICKS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeSel = 2'b01;
  logic       userLed = 1'b0;
  logic [5:0] railGood = 6'h3F;
  logic       tickEn = 1'b1;
  logic       ledOut;

  int checkCount = 0;
  int failCount  = 0;
  int cyc = 0;  // clock edges out of reset with tickEn high

  always #2.5 clk = ~clk;

  rail_blink_led #(.SLOT_TICKS(TICKS)) u_rail_blink_led (
    .clk(clk), .rst(rst), .modeSel(modeSel), .userLed(userLed),
    .railGood(railGood), .tickEn(tickEn), .ledOut(ledOut)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else if (tickEn) cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [FRAME-1:0] pattern(input int code);
    logic [FRAME-1:0] p;
    for (int j = 0; j < FRAME; j++) p[j] = (code == 0) || ((j / TICKS) < code);
    return p;
  endfunction

  task automatic alignFrame();
    do @(negedge clk); while (!(cyc >= 1 && (cyc - 1) % FRAME == 0));
  endtask

  task automatic checkFrame(input int code, input string req);
    logic [FRAME-1:0] got;
    alignFrame();
    for (int j = 0; j < FRAME; j++) begin
      got[j] = ledOut;
      if (j < FRAME - 1) @(negedge clk);
    end
    check(got == pattern(code), req, 32'(got), 32'(pattern(code)));
  endtask

  task automatic setRails(input logic [5:0] good);
    @(negedge clk);
    railGood = good;
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    check(ledOut == 1'b0, "R1 ledOut low in reset", 32'(ledOut), 32'd0);
    rst = 1'b0;
  endtask

  task automatic testAllGood();
    checkFrame(0, "R1 first frame after reset steady");
    checkFrame(0, "R4 all rails good steady on");
  endtask

  task automatic testSingleFaults();
    for (int i = 0; i < 6; i++) begin
      setRails(~(6'd1 << i));
      checkFrame(i + 1, $sformatf("R5 single fault bit %0d", i));
    end
  endtask

  task automatic testPriority();
    setRails(6'b011010);
    checkFrame(1, "R6 faults on bits 0,2,5 show code 1");
    setRails(6'b001011);
    checkFrame(3, "R6 faults on bits 2,4,5 show code 3");
  endtask

  task automatic testMidFrame();
    logic [FRAME-1:0] got;
    setRails(6'b011111);
    checkFrame(6, "R5 PL rail code 6");
    alignFrame();
    for (int j = 0; j < FRAME; j++) begin
      got[j] = ledOut;
      if (j == 6) railGood = 6'b111110;
      if (j < FRAME - 1) @(negedge clk);
    end
    check(got == pattern(6), "R7 frame unaltered by mid-frame change", 32'(got), 32'(pattern(6)));
    checkFrame(1, "R7 new code in next frame");
  endtask

  task automatic testTickGate();
    bit allLit = 1'b1;
    alignFrame();
    tickEn = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (ledOut !== 1'b1) allLit = 1'b0;
    end
    check(allLit, "R8 slot frozen while tickEn low", 32'(allLit), 32'd1);
    tickEn = 1'b1;
    checkFrame(1, "R8 frame resumes after tick gap");
  endtask

  task automatic testModes();
    @(negedge clk); modeSel = 2'b00;
    @(negedge clk); check(ledOut == 1'b0, "R2 mode 00 dark", 32'(ledOut), 32'd0);
    modeSel = 2'b11;
    @(negedge clk); check(ledOut == 1'b1, "R2 mode 11 lit", 32'(ledOut), 32'd1);
    modeSel = 2'b10; userLed = 1'b1;
    @(negedge clk); check(ledOut == 1'b1, "R3 user high", 32'(ledOut), 32'd1);
    userLed = 1'b0;
    @(negedge clk); check(ledOut == 1'b0, "R3 user low", 32'(ledOut), 32'd0);
    userLed = 1'b1;
    @(negedge clk); check(ledOut == 1'b1, "R3 user high again", 32'(ledOut), 32'd1);
    modeSel = 2'b01;
    checkFrame(1, "R5 power mode resumes code 1");
  endtask

  task automatic testResetWithFault();
    setRails(6'b011111);
    doReset();
    checkFrame(0, "R1 first frame after reset ignores fault");
    checkFrame(6, "R5 fault shown after first frame");
  endtask

  initial begin
    #(200000 * 5);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    doReset();
    testAllGood();
    testSingleFaults();
    testPriority();
    testMidFrame();
    testTickGate();
    testModes();
    testResetWithFault();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule